// File: doc/BRIEF.md
# Indirect Table Access Port

This block lets software reach several small internal configuration tables through just two registers on a 64-bit register bus. One register is a pointer: a table selector, an entry index and an autoincrement flag. The other is a data window. A read or write of the data window acts on the entry that the pointer names. The index is first trimmed to the depth of the selected table. When autoincrement is set, the pointer then steps to the next entry, and it wraps at the end of that table.

Six tables hold real storage, with depths of 4, 8, 8, 16, 256 and 512 entries. Three more selectors are legal but have no storage. They read as zero and drop writes, yet their index still steps. Any selector outside these nine is illegal and produces a one-cycle error pulse. After every write into a table with storage, the block pulses an update strobe for one cycle. The strobe carries the table id, the index and the value that was stored, so that neighbouring logic can react, for example by re-evaluating an address window when its entry changes. Writes to the interrupt-vector table keep only its server, priority and node fields.

Top module: `itap_top`

## Requirements
- R1: After reset the pointer register reads as zero, and `bus_rvalid`, `sel_err` and `upd_valid` are low.
- R2: The pointer register keeps the autoincrement flag in bit 63, the selector in bits 51:48 and the index in bits 8:0. All other bits read as zero.
- R3: A data-window write to a table with storage stores the word. A later read of the same entry returns it.
- R4: The index is ANDed with the mask of the selected table before use. The masks are: selector 0 (interrupt vectors) 7, 1 (list) 7, 2 (window) 15, 3 (domain) 255, 4 (translation) 511, 5 (event) 3, 6 (spare A) 31, 7 (spare B) 63, 8 (spare C) 255.
- R5: With autoincrement set, every data-window access to a legal selector rewrites the index as ((index AND mask) + 1) AND mask.
- R6: With autoincrement clear, a data-window access leaves the index field exactly as written, including any bits above the mask.
- R7: Selectors 6, 7 and 8 have no storage. A read returns zero, a write is dropped and raises no update strobe, and the index still steps under R5.
- R8: Selectors 9 to 15 are illegal. A data-window access with one of them returns zero, pulses `sel_err` for one cycle in the cycle after the access, and leaves the index unchanged.
- R9: A write to selector 0 stores only bits 27:16 (server and node) and bits 7:0 (priority). All other bits are stored as zero.
- R10: In the cycle after each write to a table with storage, `upd_valid` is high for one cycle. `upd_table` carries the selector, `upd_index` the masked index, and `upd_data` the stored word.
- R11: Read data appears on `bus_rdata` with `bus_rvalid` one cycle after the read request. Any other register offset reads as zero and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Register access request, one cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_off | input | OFF_W | Register offset (pointer or data window) |
| bus_wdata | input | DATA_W | Write data |
| bus_rvalid | output | 1 | Read data valid |
| bus_rdata | output | DATA_W | Read data |
| sel_err | output | 1 | Pulse: data access with an illegal selector |
| upd_valid | output | 1 | Pulse: an entry with storage was written |
| upd_table | output | 4 | Selector of the written entry |
| upd_index | output | 9 | Masked index of the written entry |
| upd_data | output | DATA_W | Value that was stored |

## Verification
The hardest case to reach is the wrap of the autoincrement at the end of each table. Because every table has a different depth, each one needs its own run that starts close to its last entry. The stimulus sets the pointer to mask minus one for each table with storage, writes three entries in a burst so that the index crosses the end, and then reads the burst back from the same start point. Unmasked high index bits, spare and illegal selectors are then each driven through the same two registers. After each of them the pointer is read back, which shows whether the index moved.

// File: rtl/itap_pkg.sv
package itap_pkg;
    localparam int SEL_W     = 4;
    localparam int IDX_W     = 9;
    localparam int NUM_BANKS = 6;
    localparam int AUTO_BIT  = 63;
    localparam int SEL_LSB   = 48;

    localparam logic [SEL_W-1:0] SEL_IVEC = 4'd0;
    localparam logic [SEL_W-1:0] SEL_LIST = 4'd1;
    localparam logic [SEL_W-1:0] SEL_WIN  = 4'd2;
    localparam logic [SEL_W-1:0] SEL_DOM  = 4'd3;
    localparam logic [SEL_W-1:0] SEL_XLAT = 4'd4;
    localparam logic [SEL_W-1:0] SEL_EVT  = 4'd5;
    localparam logic [SEL_W-1:0] SEL_SPA  = 4'd6;
    localparam logic [SEL_W-1:0] SEL_SPB  = 4'd7;
    localparam logic [SEL_W-1:0] SEL_SPC  = 4'd8;

    typedef struct packed {
        logic             autoinc;
        logic [SEL_W-1:0] sel;
        logic [IDX_W-1:0] idx;
    } ptr_t;

    function automatic logic [IDX_W-1:0] sel_mask(input logic [SEL_W-1:0] s);
        case (s)
            SEL_IVEC, SEL_LIST: return 9'd7;
            SEL_WIN:            return 9'd15;
            SEL_DOM, SEL_SPC:   return 9'd255;
            SEL_XLAT:           return 9'd511;
            SEL_EVT:            return 9'd3;
            SEL_SPA:            return 9'd31;
            SEL_SPB:            return 9'd63;
            default:            return 9'd0;
        endcase
    endfunction

    function automatic logic sel_legal(input logic [SEL_W-1:0] s);
        return s <= SEL_SPC;
    endfunction

    function automatic logic sel_backed(input logic [SEL_W-1:0] s);
        return s < SEL_W'(NUM_BANKS);
    endfunction
endpackage

// File: rtl/itap_decode.sv
module itap_decode
    import itap_pkg::*;
(
    input  logic [SEL_W-1:0] sel,
    output logic [IDX_W-1:0] mask,
    output logic             legal,
    output logic             backed
);
    always_comb begin
        mask   = sel_mask(sel);
        legal  = sel_legal(sel);
        backed = sel_backed(sel);
    end
endmodule

// File: rtl/itap_bank.sv
module itap_bank #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 64,
    parameter int IDX_W  = 9
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     a;

    assign a = idx[AW-1:0];

    generate
        if (AW < IDX_W) begin : g_hi
            logic unused_hi;
            assign unused_hi = ^idx[IDX_W-1:AW];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (we) mem[a] <= wdata;
    end

    assign rdata = mem[a];
endmodule

// File: rtl/itap_top.sv
module itap_top
    import itap_pkg::*;
#(
    parameter int                DATA_W       = 64,
    parameter int                OFF_W        = 4,
    parameter logic [OFF_W-1:0]  PTR_OFF      = 4'h2,
    parameter logic [OFF_W-1:0]  WIN_OFF      = 4'h3,
    parameter logic [DATA_W-1:0] IVEC_KEEP    = 64'h0000_0000_0FFF_00FF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [OFF_W-1:0]  bus_off,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              bus_rvalid,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              sel_err,
    output logic              upd_valid,
    output logic [SEL_W-1:0]  upd_table,
    output logic [IDX_W-1:0]  upd_index,
    output logic [DATA_W-1:0] upd_data
);
    typedef struct packed {
        ptr_t              ptr;
        logic              rvalid;
        logic [DATA_W-1:0] rdata;
        logic              err;
        logic              upd;
        logic [SEL_W-1:0]  utbl;
        logic [IDX_W-1:0]  uidx;
        logic [DATA_W-1:0] udata;
    } st_t;

    st_t st_d, st_q;

    logic [IDX_W-1:0]     mask;
    logic                 legal, backed;
    logic [IDX_W-1:0]     cur_idx;
    logic [NUM_BANKS-1:0] bank_we;
    logic [DATA_W-1:0]    wval;
    logic [DATA_W-1:0]    bank_rd [NUM_BANKS];
    logic [DATA_W-1:0]    sel_rd;
    logic [SEL_W-1:0]     cur_sel;
    logic [IDX_W-1:0]     ptr_idx;

    itap_decode u_dec (
        .sel    (st_q.ptr.sel),
        .mask   (mask),
        .legal  (legal),
        .backed (backed)
    );

    assign cur_idx = st_q.ptr.idx & mask;
    assign cur_sel = st_q.ptr.sel;
    assign ptr_idx = st_q.ptr.idx;

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            itap_bank #(
                .DEPTH  (int'(sel_mask(SEL_W'(b))) + 1),
                .DATA_W (DATA_W),
                .IDX_W  (IDX_W)
            ) u_bank (
                .clk   (clk),
                .we    (bank_we[b]),
                .idx   (cur_idx),
                .wdata (wval),
                .rdata (bank_rd[b])
            );
        end
    endgenerate

    always_comb begin
        sel_rd = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (st_q.ptr.sel == SEL_W'(b)) sel_rd = bank_rd[b];
        end
    end

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = bus_req && !bus_we;
        st_d.rdata  = '0;
        st_d.err    = 1'b0;
        st_d.upd    = 1'b0;
        bank_we     = '0;
        wval        = (st_q.ptr.sel == SEL_IVEC) ? (bus_wdata & IVEC_KEEP) : bus_wdata;

        if (bus_req && bus_off == PTR_OFF) begin
            if (bus_we) begin
                st_d.ptr.autoinc = bus_wdata[AUTO_BIT];
                st_d.ptr.sel     = bus_wdata[SEL_LSB +: SEL_W];
                st_d.ptr.idx     = bus_wdata[IDX_W-1:0];
            end else begin
                st_d.rdata[AUTO_BIT]          = st_q.ptr.autoinc;
                st_d.rdata[SEL_LSB +: SEL_W]  = st_q.ptr.sel;
                st_d.rdata[IDX_W-1:0]         = st_q.ptr.idx;
            end
        end else if (bus_req && bus_off == WIN_OFF) begin
            if (!legal) begin
                st_d.err = 1'b1;
            end else begin
                if (backed) begin
                    if (bus_we) begin
                        bank_we[st_q.ptr.sel[$clog2(NUM_BANKS)-1:0]] = 1'b1;
                        st_d.upd   = 1'b1;
                        st_d.utbl  = st_q.ptr.sel;
                        st_d.uidx  = cur_idx;
                        st_d.udata = wval;
                    end else begin
                        st_d.rdata = sel_rd;
                    end
                end
                if (st_q.ptr.autoinc) st_d.ptr.idx = (cur_idx + 1'b1) & mask;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rvalid = st_q.rvalid;
    assign bus_rdata  = st_q.rdata;
    assign sel_err    = st_q.err;
    assign upd_valid  = st_q.upd;
    assign upd_table  = st_q.utbl;
    assign upd_index  = st_q.uidx;
    assign upd_data   = st_q.udata;
endmodule

// File: rtl/itap_chk.sv
module itap_chk
    import itap_pkg::*;
#(
    parameter int               DATA_W  = 64,
    parameter int               OFF_W   = 4,
    parameter logic [OFF_W-1:0] WIN_OFF = 4'h3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req,
    input logic              bus_we,
    input logic [OFF_W-1:0]  bus_off,
    input logic              bus_rvalid,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              sel_err,
    input logic              upd_valid,
    input logic [SEL_W-1:0]  upd_table,
    input logic [IDX_W-1:0]  upd_index,
    input logic [SEL_W-1:0]  cur_sel,
    input logic [IDX_W-1:0]  ptr_idx
);
    p_rvalid_follows_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we) |=> bus_rvalid);

    p_rvalid_only_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |-> $past(bus_req && !bus_we));

    p_upd_after_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> $past(bus_req && bus_we && bus_off == WIN_OFF));

    p_upd_index_masked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> ((upd_index & ~sel_mask(upd_table)) == '0));

    p_upd_backed_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> sel_backed(upd_table));

    p_err_after_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sel_err |-> ($past(bus_req && bus_off == WIN_OFF) && !upd_valid && bus_rdata == '0));

    p_spare_reads_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rvalid && $past(bus_off == WIN_OFF) && $past(sel_legal(cur_sel) && !sel_backed(cur_sel)))
        |-> bus_rdata == '0);

    p_idx_hold_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_req) |-> $stable(ptr_idx));
endmodule

bind itap_top itap_chk #(
    .DATA_W  (DATA_W),
    .OFF_W   (OFF_W),
    .WIN_OFF (WIN_OFF)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_req    (bus_req),
    .bus_we     (bus_we),
    .bus_off    (bus_off),
    .bus_rvalid (bus_rvalid),
    .bus_rdata  (bus_rdata),
    .sel_err    (sel_err),
    .upd_valid  (upd_valid),
    .upd_table  (upd_table),
    .upd_index  (upd_index),
    .cur_sel    (cur_sel),
    .ptr_idx    (ptr_idx)
);

// File: tb/itap_top_tb_top.sv
module itap_top_tb_top;
    localparam logic [3:0]  PTR = 4'h2;
    localparam logic [3:0]  WIN = 4'h3;
    localparam logic [63:0] KEEP = 64'h0000_0000_0FFF_00FF;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        bus_req = 0, bus_we = 0;
    logic [3:0]  bus_off = 0;
    logic [63:0] bus_wdata = 0;
    logic        bus_rvalid, sel_err, upd_valid;
    logic [63:0] bus_rdata, upd_data;
    logic [3:0]  upd_table;
    logic [8:0]  upd_index;

    int checks = 0, failures = 0;

    always #10 clk = ~clk;

    itap_top dut_i (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_off(bus_off), .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
        .bus_rdata(bus_rdata), .sel_err(sel_err), .upd_valid(upd_valid),
        .upd_table(upd_table), .upd_index(upd_index), .upd_data(upd_data)
    );

    // reference model
    logic        m_auto = 0;
    logic [3:0]  m_sel = 0;
    logic [8:0]  m_idx = 0;
    logic [63:0] m_tab [int];
    logic [63:0] exp_q [$];
    string       tag_q [$];

    function automatic logic [8:0] m_mask(input logic [3:0] s);
        case (s)
            0, 1: return 9'd7;
            2: return 9'd15;
            3, 8: return 9'd255;
            4: return 9'd511;
            5: return 9'd3;
            6: return 9'd31;
            7: return 9'd63;
            default: return 9'd0;
        endcase
    endfunction

    function automatic bit m_legal(input logic [3:0] s); return s <= 8; endfunction
    function automatic bit m_backed(input logic [3:0] s); return s <= 5; endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: compare read data as it returns
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            if (exp_q.size() == 0) begin
                chk("R11 unexpected read data", 64'd1, 64'd0);
            end else begin
                logic [63:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(t, bus_rdata, e);
            end
        end
    end

    task automatic drive(input logic we, input logic [3:0] off, input logic [63:0] wd);
        @(negedge clk);
        bus_req = 1; bus_we = we; bus_off = off; bus_wdata = wd;
        @(negedge clk);
        bus_req = 0; bus_we = 0;
    endtask

    task automatic advance();
        if (m_legal(m_sel) && m_auto) m_idx = ((m_idx & m_mask(m_sel)) + 9'd1) & m_mask(m_sel);
    endtask

    task automatic wr_ptr(input logic [63:0] raw);
        drive(1, PTR, raw);
        m_auto = raw[63]; m_sel = raw[51:48]; m_idx = raw[8:0];
    endtask

    task automatic set_ptr(input logic a, input logic [3:0] s, input logic [8:0] i);
        wr_ptr({a, 11'd0, s, 39'd0, i});
    endtask

    task automatic rd_ptr(input string tag);
        exp_q.push_back({m_auto, 11'd0, m_sel, 39'd0, m_idx});
        tag_q.push_back(tag);
        drive(0, PTR, 64'd0);
    endtask

    task automatic wr_data(input logic [63:0] wd, input string tag);
        logic [8:0]  i;
        logic [63:0] st;
        bit          bk;
        i  = m_idx & m_mask(m_sel);
        st = (m_sel == 0) ? (wd & KEEP) : wd;
        bk = m_backed(m_sel);
        drive(1, WIN, wd);
        chk({tag, " R10 upd_valid"}, 64'(upd_valid), 64'(bk));
        chk({tag, " R8 sel_err"}, 64'(sel_err), 64'(!m_legal(m_sel)));
        if (bk) begin
            chk({tag, " R10 upd_table"}, 64'(upd_table), 64'(m_sel));
            chk({tag, " R10 upd_index"}, 64'(upd_index), 64'(i));
            chk({tag, " R10 upd_data"}, upd_data, st);
            m_tab[m_sel * 1024 + i] = st;
        end
        advance();
    endtask

    task automatic rd_data(input string tag);
        logic [8:0] i;
        i = m_idx & m_mask(m_sel);
        exp_q.push_back(m_backed(m_sel) ? m_tab[m_sel * 1024 + i] : 64'd0);
        tag_q.push_back(tag);
        drive(0, WIN, 64'd0);
        chk({tag, " R8 sel_err"}, 64'(sel_err), 64'(!m_legal(m_sel)));
        advance();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1
        chk("R1 rvalid", 64'(bus_rvalid), 0);
        chk("R1 sel_err", 64'(sel_err), 0);
        chk("R1 upd_valid", 64'(upd_valid), 0);
        rd_ptr("R1 pointer after reset");
        // R2: junk bits dropped
        wr_ptr(64'h8003_0000_4000_0105);
        rd_ptr("R2 pointer field layout");
        // R3 R5: burst across the wrap point of each table with storage
        for (int t = 0; t < 6; t++) begin
            logic [8:0] st;
            st = m_mask(4'(t)) - 9'd1;
            set_ptr(1, 4'(t), st);
            for (int k = 0; k < 3; k++) wr_data({8'(t), 24'h5A5A00, 32'(k) ^ 32'hFFFF_FF00}, "R3 burst write");
            rd_ptr("R5 pointer after wrap");
            set_ptr(1, 4'(t), st);
            for (int k = 0; k < 3; k++) rd_data("R3 R5 burst read");
        end
        // R9: only kept fields of interrupt-vector entries
        set_ptr(0, 0, 9'd2);
        wr_data(64'hFFFF_FFFF_FFFF_FFFF, "R9 field filter");
        exp_q.push_back(KEEP); tag_q.push_back("R9 kept fields readback");
        drive(0, WIN, 0);
        // R4 R6: high index bits masked, no autoincrement keeps raw index
        set_ptr(0, 1, 9'h1F9);
        wr_data(64'h0123_4567_89AB_CDEF, "R4 masked index write");
        rd_ptr("R6 index unchanged");
        set_ptr(0, 1, 9'd1);
        rd_data("R4 entry one via masked index");
        // R7: spare table
        set_ptr(1, 7, 9'd63);
        wr_data(64'hDEAD_BEEF_0000_0001, "R7 spare write");
        rd_ptr("R7 spare index wrapped");
        rd_data("R7 spare reads zero");
        rd_ptr("R7 spare index stepped");
        // R8: illegal selector
        set_ptr(1, 12, 9'd5);
        rd_data("R8 illegal read zero");
        wr_data(64'h1111, "R8 illegal write");
        rd_ptr("R8 index held");
        // R11: other offsets
        exp_q.push_back(64'd0); tag_q.push_back("R11 other offset reads zero");
        drive(0, 4'h0, 0);
        drive(1, 4'h0, 64'hFFFF_FFFF_FFFF_FFFF);
        rd_ptr("R11 other offset write ignored");
        repeat (3) @(negedge clk);
        chk("R11 all reads returned", 64'(exp_q.size()), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule